// File: doc/BRIEF.md
# Key-committed double-buffered control register

This block is a small control register bank for a flash and memory-mapping controller. Software first writes a staging register. The staging register holds three fields: a 3-bit command-enable mode, a boot-ROM visibility bit and a 2-bit area-select code. Nothing written there reaches the control outputs yet. The new setting takes effect only when software writes a single key byte to a separate commit register. That write copies the staged fields into an active shadow register, and the active shadow drives the decoded controls. Those controls are command-sequence enable, boot-ROM visible, and the area-remap select with its two decoded halves.

The active setting can be read back at its own address, so software can tell which value is in force and which value is only staged. A commit attempted while the staged mode holds a reserved code is refused. The active setting then stays as it was, and a sticky error flag is raised. Reading the flag returns it and clears it.

The bus is a plain single-port interface with address, write data, write strobe and read strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `keyed_ctl_regs`

## Requirements
- R1: After reset, the staging register and the active register both read 0x40 (mode 3'b010, boot bit 0, area 2'b00). The error flag reads 0x00, and the outputs cmd_en, boot_vis, area_sel, remap_window and code_space are all 0.
- R2: A write to address 0x0FD0 stores wdata[7:5] as the mode, wdata[4] as boot visibility and wdata[3:2] as the area code. Bits [1:0] are ignored and read as 0. Reading 0x0FD0 returns the staged byte, and no control output changes.
- R3: Writing exactly 0xD5 to address 0x0FD1 while the staged mode is 3'b010 or 3'b101 copies the staged fields into the active register. The outputs show the new value in the cycle after the write.
- R4: Writing any byte other than 0xD5 to 0x0FD1 leaves the active register, the outputs and the error flag unchanged.
- R5: Writing 0xD5 to 0x0FD1 while the staged mode holds any value other than 3'b010 or 3'b101 leaves the active register unchanged and sets the error flag. A read of address 0x0FD3 returns 0x01 while the flag is set and clears it, so the next read returns 0x00.
- R6: cmd_en is 1 exactly when the active mode is 3'b101. Active mode 3'b010 gives cmd_en 0.
- R7: boot_vis equals the active boot bit, and area_sel equals the active area code. remap_window is area_sel[0] (low region shown through the 0x9000–0xFFFF window), and code_space is area_sel[1] (code-area variant of the mapping).
- R8: rdata is registered: it carries the addressed value in the cycle after a cycle with re high, and 0x00 after a cycle with re low. Address 0x0FD1 and any unmapped address read 0x00.
- R9: A staging write made after a commit does not change the active register or the outputs until the next 0xD5 write to 0x0FD1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| cmd_en | output | 1 | Command-sequence and toggle execution enable |
| boot_vis | output | 1 | Boot ROM mapped in |
| area_sel | output | 2 | Active area-remap code |
| remap_window | output | 1 | Low region shown through the upper window |
| code_space | output | 1 | Code-area variant of the mapping selected |

## Verification
The hardest case to reach is a refused commit. The staging register must first hold a reserved mode while the active register holds a value that differs from reset. The key byte must then arrive, and the refusal is visible only through the stable outputs and a later read of the error flag. The stimulus first commits a legal non-reset setting. It then stages a reserved mode, sends the key, and reads the flag twice to see it set and then cleared. A wrong key byte is also sent after the first legal staging write, which proves that the key match is exact.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int CTL_W = 6;
  localparam logic [2:0] MODE_OFF = 3'b010;
  localparam logic [2:0] MODE_ON  = 3'b101;

  typedef struct packed {
    logic [2:0] mode;
    logic       boot;
    logic [1:0] area;
  } ctl_t;

  localparam ctl_t CTL_RST = '{mode: MODE_OFF, boot: 1'b0, area: 2'b00};

  function automatic logic mode_ok(input logic [2:0] m);
    return (m == MODE_OFF) || (m == MODE_ON);
  endfunction

  function automatic logic [7:0] to_byte(input ctl_t c);
    return {c, 2'b00};
  endfunction

  function automatic ctl_t from_byte(input logic [7:0] b);
    return ctl_t'(b[7:2]);
  endfunction
endpackage

// File: rtl/kc_stage_reg.sv
module kc_stage_reg
  import kc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stage,
  input  logic [7:0] wdata,
  output ctl_t       stage_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= CTL_RST;
    else if (wr_stage) stage_q <= from_byte(wdata);
  end

  // R2: staging holds its value without a staging write
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stage |=> $stable(stage_q));
endmodule

// File: rtl/kc_active_reg.sv
module kc_active_reg
  import kc_pkg::*;
#(
  parameter logic [7:0] COMMIT_KEY = 8'hD5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_commit,
  input  logic [7:0] wdata,
  input  ctl_t       stage_q,
  input  logic       rd_err,
  output ctl_t       active_q,
  output logic       err_q,
  output logic       commit_ok,
  output logic       commit_bad,
  output logic       cmd_en,
  output logic       boot_vis,
  output logic [1:0] area_sel,
  output logic       remap_window,
  output logic       code_space
);
  logic key_hit;
  assign key_hit    = wr_commit && (wdata == COMMIT_KEY);
  assign commit_ok  = key_hit && mode_ok(stage_q.mode);
  assign commit_bad = key_hit && !mode_ok(stage_q.mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active_q <= CTL_RST;
    else if (commit_ok) active_q <= stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (commit_bad) err_q <= 1'b1;
    else if (rd_err)     err_q <= 1'b0;
  end

  assign cmd_en       = (active_q.mode == MODE_ON);
  assign boot_vis     = active_q.boot;
  assign area_sel     = active_q.area;
  assign remap_window = active_q.area[0];
  assign code_space   = active_q.area[1];

  // R3: the active copy moves only after an accepted key write
  p_active_only_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_q) |-> $past(commit_ok));
  // R4: a non-key byte at the commit address touches nothing
  p_wrong_key_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wdata != COMMIT_KEY) |=> ($stable(active_q) && $stable(err_q)));
  // R5: a refused commit keeps the active copy and raises the flag
  p_bad_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_bad |=> ($stable(active_q) && err_q));
  // R5: reading the flag clears it
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !commit_bad) |=> !err_q);
  // R6: the active mode never holds a reserved code
  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(active_q.mode));
endmodule

// File: rtl/kc_read_port.sv
module kc_read_port
  import kc_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STAGE_ADDR  = 16'h0FD0,
  parameter logic [ADDR_W-1:0] ACTIVE_ADDR = 16'h0FD2,
  parameter logic [ADDR_W-1:0] ERR_ADDR    = 16'h0FD3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  ctl_t              stage_q,
  input  ctl_t              active_q,
  input  logic              err_q,
  output logic              rd_err,
  output logic [7:0]        rdata
);
  logic [7:0] rd_mux;

  assign rd_err = re && (addr == ERR_ADDR);

  always_comb begin
    rd_mux = 8'h00;
    if      (addr == STAGE_ADDR)  rd_mux = to_byte(stage_q);
    else if (addr == ACTIVE_ADDR) rd_mux = to_byte(active_q);
    else if (addr == ERR_ADDR)    rd_mux = {7'd0, err_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (re) rdata <= rd_mux;
    else         rdata <= 8'h00;
  end

  // R8: idle bus cycle gives zero read data
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> (rdata == 8'h00));
  // R2: reserved low bits never read back set
  p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == STAGE_ADDR) |=> (rdata[1:0] == 2'b00));
endmodule

// File: rtl/keyed_ctl_regs.sv
module keyed_ctl_regs
  import kc_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STAGE_ADDR  = 16'h0FD0,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 16'h0FD1,
  parameter logic [ADDR_W-1:0] ACTIVE_ADDR = 16'h0FD2,
  parameter logic [ADDR_W-1:0] ERR_ADDR    = 16'h0FD3,
  parameter logic [7:0]        COMMIT_KEY  = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  input  logic              re,
  output logic [7:0]        rdata,
  output logic              cmd_en,
  output logic              boot_vis,
  output logic [1:0]        area_sel,
  output logic              remap_window,
  output logic              code_space
);
  logic wr_stage, wr_commit, rd_err, err_q, commit_ok, commit_bad;
  ctl_t stage_q, active_q;

  assign wr_stage  = we && (addr == STAGE_ADDR);
  assign wr_commit = we && (addr == COMMIT_ADDR);

  kc_stage_reg u_stage (
    .clk(clk), .rst_n(rst_n), .wr_stage(wr_stage), .wdata(wdata), .stage_q(stage_q)
  );

  kc_active_reg #(.COMMIT_KEY(COMMIT_KEY)) u_active (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wdata(wdata),
    .stage_q(stage_q), .rd_err(rd_err), .active_q(active_q), .err_q(err_q),
    .commit_ok(commit_ok), .commit_bad(commit_bad), .cmd_en(cmd_en),
    .boot_vis(boot_vis), .area_sel(area_sel), .remap_window(remap_window),
    .code_space(code_space)
  );

  kc_read_port #(
    .ADDR_W(ADDR_W), .STAGE_ADDR(STAGE_ADDR), .ACTIVE_ADDR(ACTIVE_ADDR), .ERR_ADDR(ERR_ADDR)
  ) u_read (
    .clk(clk), .rst_n(rst_n), .re(re), .addr(addr), .stage_q(stage_q),
    .active_q(active_q), .err_q(err_q), .rd_err(rd_err), .rdata(rdata)
  );

  // R9: a staging write never moves the active outputs in the next cycle
  p_stage_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stage |=> ($stable(cmd_en) && $stable(boot_vis) && $stable(area_sel)));
endmodule

// File: tb/tb_keyed_ctl_regs.sv
module tb_keyed_ctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic cmd_en, boot_vis, remap_window, code_space;
  logic [1:0] area_sel;

  int tests = 0, fails = 0;
  bit done = 0;

  keyed_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .cmd_en(cmd_en), .boot_vis(boot_vis), .area_sel(area_sel),
    .remap_window(remap_window), .code_space(code_space)
  );

  always #5 clk = ~clk;

  // bench model of the register bank
  logic [7:0] m_stage = 8'h40, m_active = 8'h40;
  logic m_err = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic re_seen = 1'b0;

  function automatic bit legal(input logic [7:0] b);
    return b[7:5] inside {3'b010, 3'b101};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    logic [7:0] got, want;
    got  = {1'b0, cmd_en, boot_vis, area_sel, remap_window, code_space, 1'b0};
    want = {1'b0, m_active[7:5] == 3'b101, m_active[4], m_active[3:2],
            m_active[2], m_active[3], 1'b0};
    check(tag, got, want);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    if (a == 16'h0FD0) m_stage = d & 8'hFC;
    if (a == 16'h0FD1 && d == 8'hD5) begin
      if (legal(m_stage)) m_active = m_stage;
      else                m_err = 1'b1;
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    case (a)
      16'h0FD0: exp_q.push_back(m_stage);
      16'h0FD2: exp_q.push_back(m_active);
      16'h0FD3: begin exp_q.push_back({7'd0, m_err}); m_err = 1'b0; end
      default:  exp_q.push_back(8'h00);
    endcase
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  always @(posedge clk) re_seen <= re;

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (re_seen && rst_n) begin
      if (exp_q.size() == 0) check("R8 unexpected read", rdata, 8'hXX);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 outputs after reset");
    check("R1 out bits zero", {cmd_en, boot_vis, area_sel, remap_window, code_space}, 6'd0);
    rd(16'h0FD0, "R1 stage reset");
    rd(16'h0FD2, "R1 active reset");
    rd(16'h0FD3, "R1 err reset");
    rd(16'h0FD1, "R8 commit reads zero");
    rd(16'h0FD4, "R8 unmapped reads zero");
    @(negedge clk);
    check("R8 idle rdata zero", rdata, 8'h00);

    wr(16'h0FD0, 8'hB7);
    check_outs("R2 outputs unchanged by stage");
    rd(16'h0FD0, "R2 stage readback low bits cleared");
    rd(16'h0FD2, "R2 active still reset");

    wr(16'h0FD1, 8'hD4);
    check_outs("R4 wrong key ignored");
    rd(16'h0FD2, "R4 active after wrong key");
    rd(16'h0FD3, "R4 err not set");

    wr(16'h0FD1, 8'hD5);
    check_outs("R3 outputs after commit");
    check("R6 cmd_en on", {7'd0, cmd_en}, 8'h01);
    check("R7 area 01", {boot_vis, area_sel, remap_window, code_space}, 5'b10110);
    rd(16'h0FD2, "R3 active readback");

    wr(16'h0FD0, 8'h58);
    check_outs("R9 stage after commit no effect");
    rd(16'h0FD2, "R9 active unchanged");
    rd(16'h0FD0, "R9 stage holds new value");

    wr(16'h0FD1, 8'hD5);
    check("R6 cmd_en off", {7'd0, cmd_en}, 8'h00);
    check("R7 area 10", {boot_vis, area_sel, remap_window, code_space}, 5'b11001);

    wr(16'h0FD0, 8'hEC);
    wr(16'h0FD1, 8'hD5);
    check_outs("R5 reserved commit refused");
    rd(16'h0FD2, "R5 active unchanged");
    rd(16'h0FD3, "R5 err set");
    rd(16'h0FD3, "R5 err cleared by read");

    wr(16'h0FD0, 8'hAC);
    wr(16'h0FD1, 8'hD5);
    check_outs("R7 area 11 boot hidden");
    check("R6 cmd_en mode 101", {7'd0, cmd_en}, 8'h01);
    rd(16'h0FD2, "R3 second commit readback");
    rd(16'h0FD3, "R5 err stays clear");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R8 reads outstanding", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog (all) actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule